// File: doc/BRIEF.md
# Channel-Label Receive Store

This block holds the latest 32-bit word seen for each label on each of several receive channels. Every channel offers a received word together with its 8-bit label and a one-cycle valid strobe. The block parks the word in a one-deep holding slot for that channel. A round-robin arbiter then picks one holding slot at a time. The chosen word is written into a byte-wide store, one byte per cycle. The byte address is formed as `{channel, label, byte_lane}`.

A host sees the store through a read port with one cycle of latency. It can also program an enable bit for every channel-label pair. When a word for an enabled pair has been fully written, the pair is pushed into a small event queue. The interrupt request stays high while that queue holds anything. The head entry is shown on dedicated outputs, and each rising edge of the acknowledge line removes one entry.

Top module: `chan_label_store`

## Requirements
- R1: After reset, `irq_req` and `rd_valid` are low, all interrupt enables are clear, and no write is in progress.
- R2: A stored word sits at byte address `{channel, label, lane}`, where `lane` is 2 bits. It is written over four consecutive cycles, lane 0 (bits 7:0) first and lane 3 (bits 31:24) last. A later read of that channel and label returns the full 32-bit word.
- R3: A new word for a channel and label replaces the word stored there before.
- R4: Different channels keep separate slots. The same label on two channels, or two labels on one channel, never disturb each other.
- R5: Words offered by several channels in the same cycle are all stored. They are served in round-robin order, starting at the channel just after the one served last; after reset that start point is channel 0.
- R6: A channel holds at most one unserved word. A newer arrival on that channel replaces the unserved one, so only the newer word is stored and only one event is raised.
- R7: An event is queued only when the enable bit for that channel and label is set. A write to a disabled pair raises no request.
- R8: `irq_req` is high exactly while the event queue is non-empty. `irq_ch`/`irq_label` show the oldest entry. Each rising edge of `irq_ack` removes one entry, so an acknowledge held high for several cycles removes only one.
- R9: When the queue already holds `IRQ_DEPTH` entries, a further event is dropped. The word itself is still stored.
- R10: A read of a slot whose write is still in progress returns the complete new word, never a mix of old and new bytes.
- R11: `rd_valid` is high in the cycle after `rd_en`, together with the read word, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | NUM_CH | Per-channel strobe: a received word is offered |
| rx_label | input | NUM_CH*8 | Per-channel label, channel c at bits [c*8 +: 8] |
| rx_word | input | NUM_CH*32 | Per-channel word, channel c at bits [c*32 +: 32] |
| ien_we | input | 1 | Write one interrupt-enable bit |
| ien_ch | input | $clog2(NUM_CH) | Channel of the enable bit |
| ien_label | input | 8 | Label of the enable bit |
| ien_set | input | 1 | Value written to the enable bit |
| rd_en | input | 1 | Host read request |
| rd_ch | input | $clog2(NUM_CH) | Channel to read |
| rd_label | input | 8 | Label to read |
| rd_word | output | 32 | Word returned by the read |
| rd_valid | output | 1 | Read data valid |
| irq_req | output | 1 | Interrupt request: event queue non-empty |
| irq_ch | output | $clog2(NUM_CH) | Channel of the oldest queued event |
| irq_label | output | 8 | Label of the oldest queued event |
| irq_ack | input | 1 | Acknowledge; each rising edge removes one event |

## Verification
The bench builds the block with the full eight channels, so the round-robin wrap from channel 7 back to channel 0 can be observed. It also lets a channel wait through seven other writes, which is long enough for its unserved word to be replaced. The queue depth is set to 3. With that depth, four enabled arrivals are enough to reach the overflow drop, and three simultaneous arrivals fill the queue exactly, so the arbitration order can be read from the queue.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int LABEL_W        = 8;
    localparam int LABELS         = 1 << LABEL_W;
    localparam int BYTE_W         = 8;
    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int LANE_W         = $clog2(BYTES_PER_WORD);
endpackage

// File: rtl/rxs_rr_arbiter.sv
// Round-robin pick among pending channels; N must be a power of two.
module rxs_rr_arbiter #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] ptr,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_any
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] cand;

    always_comb begin
        gnt_idx = '0;
        gnt_any = 1'b0;
        cand    = '0;
        // walk from farthest to nearest so the nearest request wins
        for (int i = N - 1; i >= 0; i--) begin
            cand = ptr + IDX_W'(i);
            if (req[cand]) begin
                gnt_idx = cand;
                gnt_any = 1'b1;
            end
        end
        gnt = gnt_any ? (N'(1) << gnt_idx) : '0;
    end
endmodule

// File: rtl/rxs_evt_fifo.sv
// Small event queue; a push into a full queue is dropped unless a pop frees a slot.
module rxs_evt_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slots;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        count;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_pop  = pop && (f_q.count != '0);
        do_push = push && ((f_q.count != FULL_CNT) || do_pop);
        if (do_push) begin
            f_d.slots[f_q.wr] = push_data;
            f_d.wr = (f_q.wr == LAST_PTR) ? '0 : f_q.wr + PTR_W'(1);
        end
        if (do_pop) begin
            f_d.rd = (f_q.rd == LAST_PTR) ? '0 : f_q.rd + PTR_W'(1);
        end
        if (do_push && !do_pop) begin
            f_d.count = f_q.count + CNT_W'(1);
        end else if (do_pop && !do_push) begin
            f_d.count = f_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign head  = f_q.slots[f_q.rd];
    assign empty = (f_q.count == '0);
endmodule

// File: rtl/rxs_byte_store.sv
// Word-organised RAM written one byte lane at a time; registered word read.
module rxs_byte_store
    import rxs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                                     clk,
    input  logic                                     we,
    input  logic [$clog2(NUM_CH)+LABEL_W+LANE_W-1:0] waddr,
    input  logic [BYTE_W-1:0]                        wdata,
    input  logic                                     re,
    input  logic [$clog2(NUM_CH)+LABEL_W-1:0]        raddr,
    output logic [WORD_W-1:0]                        rdata
);
    localparam int SLOT_W = $clog2(NUM_CH) + LABEL_W;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int ADDR_W = SLOT_W + LANE_W;

    logic [WORD_W-1:0] mem [SLOTS];
    logic [SLOT_W-1:0] wslot;
    logic [LANE_W-1:0] wlane;

    assign wslot = waddr[ADDR_W-1:LANE_W];
    assign wlane = waddr[LANE_W-1:0];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wslot][wlane*BYTE_W +: BYTE_W] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/chan_label_store.sv
module chan_label_store
    import rxs_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int IRQ_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           rx_valid,
    input  logic [NUM_CH*LABEL_W-1:0]   rx_label,
    input  logic [NUM_CH*WORD_W-1:0]    rx_word,
    input  logic                        ien_we,
    input  logic [$clog2(NUM_CH)-1:0]   ien_ch,
    input  logic [LABEL_W-1:0]          ien_label,
    input  logic                        ien_set,
    input  logic                        rd_en,
    input  logic [$clog2(NUM_CH)-1:0]   rd_ch,
    input  logic [LABEL_W-1:0]          rd_label,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        rd_valid,
    output logic                        irq_req,
    output logic [$clog2(NUM_CH)-1:0]   irq_ch,
    output logic [LABEL_W-1:0]          irq_label,
    input  logic                        irq_ack
);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int SLOT_W  = CH_W + LABEL_W;
    localparam int ADDR_W  = SLOT_W + LANE_W;
    localparam int SLOTS   = 1 << SLOT_W;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES_PER_WORD - 1);

    typedef struct packed {
        logic                                busy;
        logic [LANE_W-1:0]                   lane;
        logic [CH_W-1:0]                     cur_ch;
        logic [LABEL_W-1:0]                  cur_label;
        logic [WORD_W-1:0]                   cur_word;
        logic [NUM_CH-1:0]                   pend_v;
        logic [NUM_CH-1:0][LABEL_W-1:0]      pend_label;
        logic [NUM_CH-1:0][WORD_W-1:0]       pend_word;
        logic [CH_W-1:0]                     rr_ptr;
        logic                                ack_q;
        logic                                rd_valid;
        logic                                rd_byp;
        logic [WORD_W-1:0]                   rd_byp_word;
        logic [SLOTS-1:0]                    ien;
    } state_t;

    state_t s_d, s_q;

    // arbiter
    logic [NUM_CH-1:0] gnt_vec;
    logic [CH_W-1:0]   gnt_idx;
    logic              gnt_any;

    // byte write port
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;

    // event queue
    logic               evt_push;
    logic               evt_pop;
    logic               evt_empty;
    logic [SLOT_W-1:0]  evt_head;

    logic commit;
    logic can_load;

    rxs_rr_arbiter #(.N(NUM_CH)) u_arb (
        .req     (s_q.pend_v),
        .ptr     (s_q.rr_ptr),
        .gnt     (gnt_vec),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    rxs_byte_store #(.NUM_CH(NUM_CH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .re    (rd_en),
        .raddr ({rd_ch, rd_label}),
        .rdata (mem_rdata)
    );

    rxs_evt_fifo #(.DEPTH(IRQ_DEPTH), .W(SLOT_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (evt_push),
        .push_data ({s_q.cur_ch, s_q.cur_label}),
        .pop       (evt_pop),
        .head      (evt_head),
        .empty     (evt_empty)
    );

    always_comb begin
        s_d = s_q;

        // byte-serial write of the word in flight
        mem_we    = s_q.busy;
        mem_addr  = {s_q.cur_ch, s_q.cur_label, s_q.lane};
        mem_wdata = s_q.cur_word[s_q.lane*BYTE_W +: BYTE_W];
        commit    = s_q.busy && (s_q.lane == LAST_LANE);
        can_load  = !s_q.busy || commit;

        if (s_q.busy) begin
            if (commit) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.lane = s_q.lane + LANE_W'(1);
            end
        end

        // hand the next pending word to the writer
        if (can_load && gnt_any) begin
            s_d.busy            = 1'b1;
            s_d.lane            = '0;
            s_d.cur_ch          = gnt_idx;
            s_d.cur_label       = s_q.pend_label[gnt_idx];
            s_d.cur_word        = s_q.pend_word[gnt_idx];
            s_d.pend_v[gnt_idx] = 1'b0;
            s_d.rr_ptr          = gnt_idx + CH_W'(1);
        end

        // fresh arrivals take the holding slot, newest wins
        for (int c = 0; c < NUM_CH; c++) begin
            if (rx_valid[c]) begin
                s_d.pend_v[c]     = 1'b1;
                s_d.pend_label[c] = rx_label[c*LABEL_W +: LABEL_W];
                s_d.pend_word[c]  = rx_word[c*WORD_W +: WORD_W];
            end
        end

        // interrupt-enable table
        if (ien_we) begin
            s_d.ien[{ien_ch, ien_label}] = ien_set;
        end

        // events and acknowledge edge
        evt_push  = commit && s_q.ien[{s_q.cur_ch, s_q.cur_label}];
        evt_pop   = irq_ack && !s_q.ack_q;
        s_d.ack_q = irq_ack;

        // host read with bypass of the slot under write
        s_d.rd_valid    = rd_en;
        s_d.rd_byp      = rd_en && s_q.busy && (s_q.cur_ch == rd_ch)
                          && (s_q.cur_label == rd_label);
        s_d.rd_byp_word = s_q.cur_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_word   = s_q.rd_byp ? s_q.rd_byp_word : mem_rdata;
    assign rd_valid  = s_q.rd_valid;
    assign irq_req   = !evt_empty;
    assign irq_ch    = evt_head[SLOT_W-1:LABEL_W];
    assign irq_label = evt_head[LABEL_W-1:0];
endmodule

// File: rtl/chan_label_store_chk.sv
module chan_label_store_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              irq_ack,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              mem_we,
    input logic [1:0]        mem_lane,
    input logic [NUM_CH-1:0] grant
);
    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_lane_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |-> (mem_lane == 2'd0));

    assert_lane_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_lane != 2'd3) |=> (mem_we && mem_lane == $past(mem_lane) + 2'd1));

    assert_irq_fall_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req) |-> $past(irq_ack));

    assert_rd_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_valid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

bind chan_label_store chan_label_store_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .mem_we   (mem_we),
    .mem_lane (mem_addr[1:0]),
    .grant    (gnt_vec)
);

// File: tb/test_chan_label_store.sv
module test_chan_label_store;
    localparam int NUM_CH = 8;
    localparam int DEPTH  = 3;
    localparam int NV     = 10;

    // {channel[2:0], label[7:0], word[31:0]}
    localparam logic [42:0] VEC [NV] = '{
        {3'd0, 8'h00, 32'h1122_3344},
        {3'd1, 8'h00, 32'hA5A5_0001},
        {3'd7, 8'hFF, 32'hDEAD_BEEF},
        {3'd3, 8'h5A, 32'h0102_0304},
        {3'd0, 8'hFF, 32'hCAFE_F00D},
        {3'd4, 8'h81, 32'h8000_0001},
        {3'd2, 8'h10, 32'h1357_9BDF},
        {3'd5, 8'h10, 32'h2468_ACE0},
        {3'd0, 8'h00, 32'h5555_AAAA},
        {3'd7, 8'hFF, 32'h0F0F_F0F0}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NUM_CH-1:0]      rx_valid = '0;
    logic [NUM_CH*8-1:0]    rx_label = '0;
    logic [NUM_CH*32-1:0]   rx_word = '0;
    logic                   ien_we = 1'b0;
    logic [2:0]             ien_ch = '0;
    logic [7:0]             ien_label = '0;
    logic                   ien_set = 1'b0;
    logic                   rd_en = 1'b0;
    logic [2:0]             rd_ch = '0;
    logic [7:0]             rd_label = '0;
    logic [31:0]            rd_word;
    logic                   rd_valid;
    logic                   irq_req;
    logic [2:0]             irq_ch;
    logic [7:0]             irq_label;
    logic                   irq_ack = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    chan_label_store #(.NUM_CH(NUM_CH), .IRQ_DEPTH(DEPTH)) i_chan_label_store (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_label(rx_label),
        .rx_word(rx_word), .ien_we(ien_we), .ien_ch(ien_ch), .ien_label(ien_label),
        .ien_set(ien_set), .rd_en(rd_en), .rd_ch(rd_ch), .rd_label(rd_label),
        .rd_word(rd_word), .rd_valid(rd_valid), .irq_req(irq_req), .irq_ch(irq_ch),
        .irq_label(irq_label), .irq_ack(irq_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int ch, input logic [7:0] lab, input logic [31:0] w);
        rx_valid[ch]        = 1'b1;
        rx_label[ch*8 +: 8] = lab;
        rx_word[ch*32 +: 32] = w;
    endtask

    task automatic release_rx();
        @(negedge clk);
        rx_valid = '0;
    endtask

    task automatic send1(input int ch, input logic [7:0] lab, input logic [31:0] w);
        @(negedge clk);
        put(ch, lab, w);
        release_rx();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ien(input logic [2:0] ch, input logic [7:0] lab, input logic v);
        @(negedge clk);
        ien_we = 1'b1; ien_ch = ch; ien_label = lab; ien_set = v;
        @(negedge clk);
        ien_we = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] ch, input logic [7:0] lab,
                             output logic [31:0] w);
        @(negedge clk);
        rd_en = 1'b1; rd_ch = ch; rd_label = lab;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_valid === 1'b1, "R11 rd_valid after read", 64'(rd_valid), 64'd1);
        w = rd_word;
        @(negedge clk);
        chk(rd_valid === 1'b0, "R11 rd_valid drops", 64'(rd_valid), 64'd0);
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic expect_head(input logic [2:0] ch, input logic [7:0] lab, input string req);
        chk(irq_req === 1'b1 && {irq_ch, irq_label} === {ch, lab}, req,
            64'({irq_req, irq_ch, irq_label}), 64'({1'b1, ch, lab}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] exp;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq_req === 1'b0, "R1 irq_req after reset", 64'(irq_req), 64'd0);
        chk(rd_valid === 1'b0, "R1 rd_valid after reset", 64'(rd_valid), 64'd0);

        // table walk: store all vectors (no enables set)
        for (int i = 0; i < NV; i++) begin
            send1(int'(VEC[i][42:40]), VEC[i][39:32], VEC[i][31:0]);
            idle(8);
        end
        // R7 nothing enabled so nothing raised
        chk(irq_req === 1'b0, "R7 no event for disabled labels", 64'(irq_req), 64'd0);
        for (int i = 0; i < NV; i++) begin
            exp = VEC[i][31:0];
            for (int k = i + 1; k < NV; k++) begin
                if (VEC[k][42:32] == VEC[i][42:32]) exp = VEC[k][31:0];
            end
            host_read(VEC[i][42:40], VEC[i][39:32], got);
            chk(got === exp, "R2 R3 R4 stored word readback", 64'(got), 64'(exp));
        end

        // R5 round robin: pointer is at 0 after the last grant to channel 7
        set_ien(3'd0, 8'h20, 1'b1);
        set_ien(3'd3, 8'h20, 1'b1);
        set_ien(3'd5, 8'h20, 1'b1);
        set_ien(3'd1, 8'h21, 1'b1);
        set_ien(3'd7, 8'h21, 1'b1);
        @(negedge clk);
        put(5, 8'h20, 32'h0000_0505);
        put(0, 8'h20, 32'h0000_0000);
        put(3, 8'h20, 32'h0000_0303);
        release_rx();
        idle(20);
        expect_head(3'd0, 8'h20, "R5 first served ch0");
        pulse_ack();
        expect_head(3'd3, 8'h20, "R5 second served ch3");
        pulse_ack();
        expect_head(3'd5, 8'h20, "R5 third served ch5");
        pulse_ack();
        chk(irq_req === 1'b0, "R8 queue empty after three acks", 64'(irq_req), 64'd0);
        host_read(3'd3, 8'h20, got);
        chk(got === 32'h0000_0303, "R5 simultaneous word stored", 64'(got), 64'h303);

        // pointer now 6: channel 7 ahead of channel 1
        @(negedge clk);
        put(1, 8'h21, 32'h0000_0121);
        put(7, 8'h21, 32'h0000_0721);
        release_rx();
        idle(14);
        expect_head(3'd7, 8'h21, "R5 wrap serves ch7 first");
        pulse_ack();
        expect_head(3'd1, 8'h21, "R5 then ch1");
        pulse_ack();

        // R8 held acknowledge removes one entry
        send1(0, 8'h20, 32'hAAAA_0000);
        idle(8);
        send1(3, 8'h20, 32'hAAAA_0003);
        idle(8);
        @(negedge clk);
        irq_ack = 1'b1;
        idle(4);
        irq_ack = 1'b0;
        @(negedge clk);
        expect_head(3'd3, 8'h20, "R8 held ack pops one");
        pulse_ack();
        chk(irq_req === 1'b0, "R8 irq_req low when empty", 64'(irq_req), 64'd0);

        // R9 overflow: fourth event dropped, word still stored
        send1(0, 8'h20, 32'hB000_0000);
        idle(8);
        send1(3, 8'h20, 32'hB000_0003);
        idle(8);
        send1(5, 8'h20, 32'hB000_0005);
        idle(8);
        send1(1, 8'h21, 32'hB000_0121);
        idle(8);
        expect_head(3'd0, 8'h20, "R9 oldest kept");
        pulse_ack();
        expect_head(3'd3, 8'h20, "R9 second kept");
        pulse_ack();
        expect_head(3'd5, 8'h20, "R9 third kept");
        pulse_ack();
        chk(irq_req === 1'b0, "R9 fourth event dropped", 64'(irq_req), 64'd0);
        host_read(3'd1, 8'h21, got);
        chk(got === 32'hB000_0121, "R9 dropped event word stored", 64'(got), 64'hB0000121);

        // R6 unserved word replaced by newer arrival on the same channel
        set_ien(3'd7, 8'h30, 1'b1);
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) put(c, 8'h30, 32'h100 + 32'(c));
        release_rx();
        @(negedge clk);
        put(7, 8'h30, 32'hBBBB_0007);
        release_rx();
        idle(40);
        expect_head(3'd7, 8'h30, "R6 one event for ch7");
        pulse_ack();
        chk(irq_req === 1'b0, "R6 only one event", 64'(irq_req), 64'd0);
        host_read(3'd7, 8'h30, got);
        chk(got === 32'hBBBB_0007, "R6 newer word stored", 64'(got), 64'hBBBB0007);
        host_read(3'd6, 8'h30, got);
        chk(got === 32'h0000_0106, "R4 neighbour channel intact", 64'(got), 64'h106);

        // R10 read during byte-serial write returns the whole new word
        send1(2, 8'h10, 32'hFEDC_BA98);
        @(negedge clk);
        host_read(3'd2, 8'h10, got);
        chk(got === 32'hFEDC_BA98, "R10 read during write", 64'(got), 64'hFEDCBA98);
        idle(6);
        host_read(3'd2, 8'h10, got);
        chk(got === 32'hFEDC_BA98, "R3 word after write", 64'(got), 64'hFEDCBA98);
        host_read(3'd5, 8'h10, got);
        chk(got === 32'h2468_ACE0, "R4 same label other channel", 64'(got), 64'h2468ACE0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule